// File: doc/BRIEF.md
# Low-Power Configuration Sequencer

This block sits on the control side of a self-refreshing memory. It captures a small power-configuration word and decides which standby state the memory is in. A configuration word is loaded by an ordinary write cycle that falls inside a short window opened by the falling edge of the active-low power-control input. The low address bits of that write carry the word, and the data bus plays no part.

When a power-control low period passes its window with no such write, the programmed standby state takes effect. That state is either partial self-refresh of a chosen region or deep power-down. A reduced-size mode limits the accessible region once the power-control input is high again. Leaving deep power-down starts a recovery interval, and every configuration field returns to its default.

All durations are set in microseconds and turned into clock ticks by a ticks-per-microsecond parameter. The block reports the current state, the stored word and the address region that is refreshed or accessible. It also raises error flags for accesses that are not allowed.

Top module: `lp_mode_seq`

## Requirements
- R1: After reset the state output is ACTIVE (code 0), the stored word is 5'b10000, the region spans 000000h..1FFFFFh with range_valid high, and all three error flags are low.
- R2: A write strobe (cs_n low, we_n low, lb_n or ub_n low) sampled within the first WIN_US*TICKS_PER_US clock edges after the power-control fall is captured, with the first such write winning. Its address bits [4:0] are loaded into the stored word when the window closes while the power-control input is still low.
- R3: A write strobe outside that window, or a window cut short by the power-control input rising before it closes, leaves the stored word unchanged.
- R4: A captured word whose bits [1:0] equal 2'b01, or whose address bits above bit 4 are not all zero, leaves the stored word unchanged and sets err_rsvd. err_rsvd stays high until reset.
- R5: When the window closes with no captured write, the state becomes SLEEP (code 2) if bit 4 of the stored word is 1, and DEEP (code 3) if bit 4 is 0.
- R6: SLEEP and DEEP last at least MIN_US*TICKS_PER_US clock edges from the power-control fall. They end on the first edge after that at which the power-control input is high.
- R7: On leaving a power-control low period other than DEEP, the state becomes REDUCED (code 1) if bit 3 of the stored word is 1, and ACTIVE otherwise. A newly loaded word therefore takes effect only after the input returns high.
- R8: Leaving DEEP enters RECOVER (code 4) for REC_US*TICKS_PER_US clocks and resets the stored word to 5'b10000; the state then becomes ACTIVE. Power-control falls during RECOVER are ignored.
- R9: The region follows the stored word. Bits [1:0] select the size: 00 selects the full array, 10 half, 11 quarter. Bit 2 selects the half: 0 bottom, 1 top. The resulting regions are 000000h..0FFFFFh, 000000h..07FFFFh, 100000h..1FFFFFh and 180000h..1FFFFFh. range_valid is low in DEEP and RECOVER.
- R10: An access (cs_n low, a byte strobe low, power-control high) in REDUCED to an address outside the region raises err_range for one clock on the next edge.
- R11: An access during RECOVER raises err_recov for one clock on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zz_n | input | 1 | Active-low power-control request |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| lb_n | input | 1 | Active-low lower byte strobe |
| ub_n | input | 1 | Active-low upper byte strobe |
| addr | input | ADDR_W | Access address; bits [4:0] carry the configuration word |
| pstate | output | 3 | Power state: 0 ACTIVE, 1 REDUCED, 2 SLEEP, 3 DEEP, 4 RECOVER |
| mode_reg | output | 5 | Stored configuration word |
| range_lo | output | ADDR_W | Lowest address of the refreshed or accessible region |
| range_hi | output | ADDR_W | Highest address of that region |
| range_valid | output | 1 | Region meaningful (low in DEEP and RECOVER) |
| err_range | output | 1 | One-clock flag: access outside the region in REDUCED |
| err_recov | output | 1 | One-clock flag: access during RECOVER |
| err_rsvd | output | 1 | Sticky flag: rejected configuration word |

## Verification
The hardest situation to reach is an early return of the power-control input while in DEEP. The block must then stay down until the minimum low time has run, and only then move to recovery with the stored word reset. The stimulus first loads a word with deep power-down enabled and leaves the update period. It then drops the power-control input with no write, raises it again a few clocks after DEEP is entered, and holds it high through the minimum time. During the recovery that follows, the stimulus pulses the power-control input and performs an access, so the ignored fall and the recovery error are both observed.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      PS_ACTIVE  = 3'd0,
      PS_REDUCED = 3'd1,
      PS_SLEEP   = 3'd2,
      PS_DEEP    = 3'd3,
      PS_RECOVER = 3'd4
   } pstate_e;

   localparam int unsigned CFG_W = 5;

   // field positions of the configuration word
   localparam int unsigned F_DEEP_OFF = 4;  // 1: deep power-down disabled
   localparam int unsigned F_REDUCED  = 3;  // 1: reduced size instead of partial refresh
   localparam int unsigned F_TOP      = 2;  // 1: upper half of the array

   localparam logic [CFG_W-1:0] CFG_DEFAULT = 5'b10000;
   localparam logic [1:0]       SIZE_RSVD   = 2'b01;

endpackage

// File: rtl/lpm_range_dec.sv
module lpm_range_dec
   import lpm_pkg::*;
#(
   parameter int unsigned ADDR_W = 21
) (
   input  logic [CFG_W-1:0]  cfg,
   output logic [ADDR_W-1:0] lo,
   output logic [ADDR_W-1:0] hi
);

   localparam logic [ADDR_W-1:0] ALL1    = '1;
   localparam logic [ADDR_W-1:0] HALF_M1 = ALL1 >> 1;
   localparam logic [ADDR_W-1:0] QTR_M1  = ALL1 >> 2;

   logic [ADDR_W-1:0] span_m1;

   always_comb begin
      case (cfg[1:0])
         2'b10:   span_m1 = HALF_M1;
         2'b11:   span_m1 = QTR_M1;
         default: span_m1 = ALL1;
      endcase
   end

   // power-of-two region: top region starts at the complement of span-1
   always_comb begin
      if (cfg[F_TOP]) begin
         lo = ~span_m1;
         hi = ALL1;
      end else begin
         lo = '0;
         hi = span_m1;
      end
   end

endmodule

// File: rtl/lpm_zz_track.sv
module lpm_zz_track #(
   parameter int unsigned ADDR_W    = 21,
   parameter int unsigned WIN_TICKS = 4,
   parameter int unsigned MIN_TICKS = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zz_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic              arm_en,
   input  logic              lp_hold,
   output logic              decide,
   output logic              leave,
   output logic              pend_v,
   output logic [ADDR_W-1:0] pend_a
);

   localparam int unsigned   CW    = $clog2(MIN_TICKS + 1);
   localparam logic [CW-1:0] WIN_C = CW'(WIN_TICKS);
   localparam logic [CW-1:0] MIN_C = CW'(MIN_TICKS);

   logic          zz_q;
   logic          in_low;
   logic [CW-1:0] low_cnt;
   logic          fall;

   assign fall   = zz_q & ~zz_n & arm_en & ~in_low;
   assign decide = in_low & ~zz_n & (low_cnt == WIN_C);
   assign leave  = in_low & zz_n & (~lp_hold | (low_cnt >= MIN_C));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zz_q    <= 1'b1;
         in_low  <= 1'b0;
         low_cnt <= '0;
         pend_v  <= 1'b0;
         pend_a  <= '0;
      end else begin
         zz_q <= zz_n;
         if (fall) begin
            in_low  <= 1'b1;
            low_cnt <= CW'(1);
            pend_v  <= wr_stb;
            pend_a  <= addr;
         end else if (leave) begin
            in_low <= 1'b0;
            pend_v <= 1'b0;
         end else if (in_low) begin
            if (!zz_n && (low_cnt < WIN_C) && wr_stb && !pend_v) begin
               pend_v <= 1'b1;
               pend_a <= addr;
            end
            if (low_cnt < MIN_C) low_cnt <= low_cnt + CW'(1);
         end
      end
   end

endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
   import lpm_pkg::*;
#(
   parameter int unsigned ADDR_W       = 21,
   parameter int unsigned TICKS_PER_US = 4,
   parameter int unsigned WIN_US       = 1,
   parameter int unsigned MIN_US       = 10,
   parameter int unsigned REC_US       = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zz_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              lb_n,
   input  logic              ub_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [2:0]        pstate,
   output logic [4:0]        mode_reg,
   output logic [ADDR_W-1:0] range_lo,
   output logic [ADDR_W-1:0] range_hi,
   output logic              range_valid,
   output logic              err_range,
   output logic              err_recov,
   output logic              err_rsvd
);

   localparam int unsigned WIN_TICKS = WIN_US * TICKS_PER_US;
   localparam int unsigned MIN_TICKS = MIN_US * TICKS_PER_US;
   localparam int unsigned REC_TICKS = REC_US * TICKS_PER_US;
   localparam int unsigned RW        = $clog2(REC_TICKS + 1);
   localparam logic [RW-1:0] REC_LAST = RW'(REC_TICKS - 1);

   generate
      if (ADDR_W < CFG_W + 1) begin : g_bad_addr
         $error("lp_mode_seq: ADDR_W too small for the configuration word");
      end
      if (TICKS_PER_US < 1 || WIN_US < 1) begin : g_bad_win
         $error("lp_mode_seq: update window must be at least one tick");
      end
      if (WIN_TICKS >= MIN_TICKS) begin : g_bad_min
         $error("lp_mode_seq: minimum low time must exceed the update window");
      end
      if (REC_TICKS < 2) begin : g_bad_rec
         $error("lp_mode_seq: recovery must last at least two ticks");
      end
   endgenerate

   pstate_e           state;
   logic [CFG_W-1:0]  cfg;
   logic [RW-1:0]     rec_cnt;
   logic              wr_stb, acc;
   logic              decide, leave, pend_v;
   logic [ADDR_W-1:0] pend_a;
   logic              lp_hold, bad_word, out_rng;
   logic [ADDR_W-1:0] lo, hi;

   assign wr_stb   = ~cs_n & ~we_n & (~lb_n | ~ub_n);
   assign acc      = ~cs_n & (~lb_n | ~ub_n) & zz_n;
   assign lp_hold  = (state == PS_SLEEP) || (state == PS_DEEP);
   assign bad_word = (pend_a[ADDR_W-1:CFG_W] != '0) || (pend_a[1:0] == SIZE_RSVD);
   assign out_rng  = (addr < lo) || (addr > hi);

   lpm_zz_track #(
      .ADDR_W   (ADDR_W),
      .WIN_TICKS(WIN_TICKS),
      .MIN_TICKS(MIN_TICKS)
   ) i_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .zz_n   (zz_n),
      .wr_stb (wr_stb),
      .addr   (addr),
      .arm_en (state != PS_RECOVER),
      .lp_hold(lp_hold),
      .decide (decide),
      .leave  (leave),
      .pend_v (pend_v),
      .pend_a (pend_a)
   );

   lpm_range_dec #(
      .ADDR_W(ADDR_W)
   ) i_range (
      .cfg(cfg),
      .lo (lo),
      .hi (hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= PS_ACTIVE;
         cfg       <= CFG_DEFAULT;
         rec_cnt   <= '0;
         err_range <= 1'b0;
         err_recov <= 1'b0;
         err_rsvd  <= 1'b0;
      end else begin
         err_range <= (state == PS_REDUCED) && acc && out_rng;
         err_recov <= (state == PS_RECOVER) && acc;
         if (state == PS_RECOVER) begin
            if (rec_cnt == REC_LAST) state <= PS_ACTIVE;
            else                     rec_cnt <= rec_cnt + RW'(1);
         end else if (decide) begin
            if (pend_v) begin
               if (bad_word) err_rsvd <= 1'b1;
               else          cfg      <= pend_a[CFG_W-1:0];
            end else begin
               state <= cfg[F_DEEP_OFF] ? PS_SLEEP : PS_DEEP;
            end
         end else if (leave) begin
            if (state == PS_DEEP) begin
               state   <= PS_RECOVER;
               rec_cnt <= '0;
               cfg     <= CFG_DEFAULT;
            end else begin
               state <= cfg[F_REDUCED] ? PS_REDUCED : PS_ACTIVE;
            end
         end
      end
   end

   assign pstate      = state;
   assign mode_reg    = cfg;
   assign range_lo    = lo;
   assign range_hi    = hi;
   assign range_valid = (state != PS_DEEP) && (state != PS_RECOVER);

endmodule

// File: rtl/lp_mode_seq_chk.sv
module lp_mode_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       zz_n,
   input logic [2:0] pstate,
   input logic [4:0] mode_reg,
   input logic       err_recov,
   input logic       err_rsvd
);

   assert_no_rsvd_stored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_reg[1:0] != 2'b01);

   assert_rsvd_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_rsvd |=> err_rsvd);

   assert_deep_entry_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 3'd3 && $past(pstate) != 3'd3) |-> !$past(zz_n));

   assert_deep_exit_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pstate) == 3'd3 && pstate != 3'd3) |-> pstate == 3'd4);

   assert_recover_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == 3'd4) |-> mode_reg == 5'b10000);

   assert_recov_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_recov |-> $past(pstate) == 3'd4);

endmodule

bind lp_mode_seq lp_mode_seq_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .zz_n     (zz_n),
   .pstate   (pstate),
   .mode_reg (mode_reg),
   .err_recov(err_recov),
   .err_rsvd (err_rsvd)
);

// File: tb/test_lp_mode_seq.sv
module test_lp_mode_seq;

   localparam int WIN = 4;
   localparam int MIN = 40;
   localparam int REC = 800;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic zz_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
   logic [20:0] addr = '0;
   logic [2:0]  pstate;
   logic [4:0]  mode_reg;
   logic [20:0] range_lo, range_hi;
   logic        range_valid, err_range, err_recov, err_rsvd;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   lp_mode_seq i_lp_mode_seq (
      .clk(clk), .rst_n(rst_n), .zz_n(zz_n), .cs_n(cs_n), .we_n(we_n),
      .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .pstate(pstate),
      .mode_reg(mode_reg), .range_lo(range_lo), .range_hi(range_hi),
      .range_valid(range_valid), .err_range(err_range),
      .err_recov(err_recov), .err_rsvd(err_rsvd)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // region per R9, written from the region table
   task automatic region(input logic [4:0] w, output int lo, output int hi);
      lo = 0; hi = 'h1FFFFF;
      if (w[1:0] == 2'b10) begin
         if (w[2]) begin lo = 'h100000; hi = 'h1FFFFF; end
         else      begin lo = 0;        hi = 'h0FFFFF; end
      end else if (w[1:0] == 2'b11) begin
         if (w[2]) begin lo = 'h180000; hi = 'h1FFFFF; end
         else      begin lo = 0;        hi = 'h07FFFF; end
      end
   endtask

   // behavioural reference: 0 active, 1 reduced, 2 sleep, 3 deep, 4 recover
   int          m_state, m_ticks, m_rec;
   logic [4:0]  m_word;
   bit          m_low, m_have, m_prev_zz, m_erng, m_erec, m_rsvd;
   logic [20:0] m_cap;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_word = 5'b10000; m_low = 0; m_ticks = 0; m_have = 0;
         m_cap = 0; m_rec = 0; m_prev_zz = 1; m_erng = 0; m_erec = 0; m_rsvd = 0;
      end else begin
         bit wr, acc, start, close, quit;
         int lo, hi;
         wr  = !cs_n && !we_n && (!lb_n || !ub_n);
         acc = !cs_n && (!lb_n || !ub_n) && zz_n;
         region(m_word, lo, hi);
         m_erng = (m_state == 1) && acc && (int'(addr) < lo || int'(addr) > hi);
         m_erec = (m_state == 4) && acc;
         start = m_prev_zz && !zz_n && m_state != 4 && !m_low;
         close = m_low && !zz_n && m_ticks == WIN;
         quit  = m_low && zz_n && (!(m_state == 2 || m_state == 3) || m_ticks >= MIN);
         if (m_state == 4) begin
            if (m_rec == REC - 1) m_state = 0; else m_rec++;
         end else if (close) begin
            if (m_have) begin
               if (m_cap[20:5] != 0 || m_cap[1:0] == 2'b01) m_rsvd = 1;
               else m_word = m_cap[4:0];
            end else m_state = m_word[4] ? 2 : 3;
         end else if (quit) begin
            if (m_state == 3) begin m_state = 4; m_rec = 0; m_word = 5'b10000; end
            else m_state = m_word[3] ? 1 : 0;
         end
         if (start) begin
            m_low = 1; m_ticks = 1; m_have = wr; m_cap = addr;
         end else if (quit) begin
            m_low = 0; m_have = 0;
         end else if (m_low) begin
            if (!zz_n && m_ticks < WIN && wr && !m_have) begin m_have = 1; m_cap = addr; end
            if (m_ticks < MIN) m_ticks++;
         end
         m_prev_zz = zz_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int lo, hi;
         region(m_word, lo, hi);
         chk("R5/R6/R7/R8 state", int'(pstate), m_state);
         chk("R2/R3/R4 word", int'(mode_reg), int'(m_word));
         chk("R9 lo", int'(range_lo), lo);
         chk("R9 hi", int'(range_hi), hi);
         chk("R9 valid", int'(range_valid), (m_state != 3 && m_state != 4) ? 1 : 0);
         chk("R10 err_range", int'(err_range), int'(m_erng));
         chk("R11 err_recov", int'(err_recov), int'(m_erec));
         chk("R4 err_rsvd", int'(err_rsvd), int'(m_rsvd));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cyc(input logic [20:0] a);
      cs_n = 0; we_n = 0; lb_n = 0; addr = a;
      @(negedge clk);
      cs_n = 1; we_n = 1; lb_n = 1;
   endtask

   task automatic rd_acc(input logic [20:0] a);
      cs_n = 0; lb_n = 0; addr = a;
      @(negedge clk);
      cs_n = 1; lb_n = 1;
   endtask

   task automatic cfg_write(input logic [20:0] a);
      zz_n = 0;
      idle(1);
      wr_cyc(a);
      idle(6);
      zz_n = 1;
      idle(3);
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      idle(1);
      chk("R1 reset state", int'(pstate), 0);
      chk("R1 reset word", int'(mode_reg), 'h10);
      chk("R1 reset hi", int'(range_hi), 'h1FFFFF);

      // plain sleep, then early return of zz_n held by the minimum time
      zz_n = 0; idle(50);
      chk("R5 sleep entered", int'(pstate), 2);
      zz_n = 1; idle(2);
      chk("R7 back to active", int'(pstate), 0);
      zz_n = 0; idle(8); zz_n = 1; idle(5);
      chk("R6 sleep held", int'(pstate), 2);
      idle(40);
      chk("R6 sleep left", int'(pstate), 0);

      // load top quarter, refresh mode
      cfg_write(21'h17);
      chk("R2 word loaded", int'(mode_reg), 'h17);
      chk("R9 top quarter lo", int'(range_lo), 'h180000);

      // write after the window: ignored, sleep entered
      zz_n = 0; idle(6); wr_cyc(21'h10); idle(40);
      chk("R5 sleep after late write", int'(pstate), 2);
      zz_n = 1; idle(2);
      chk("R3 late write ignored", int'(mode_reg), 'h17);

      // window cut short by zz_n rising
      zz_n = 0; idle(1); cs_n = 0; we_n = 0; lb_n = 0; addr = 21'h10;
      @(negedge clk);
      cs_n = 1; we_n = 1; lb_n = 1; zz_n = 1;
      idle(8);
      chk("R3 aborted window", int'(mode_reg), 'h17);

      // reduced size, bottom half
      cfg_write(21'h1A);
      chk("R7 reduced after rise", int'(pstate), 1);
      rd_acc(21'h0FFFFF);
      chk("R10 inside region", int'(err_range), 0);
      rd_acc(21'h100000);
      chk("R10 outside region", int'(err_range), 1);

      // rejected words
      cfg_write(21'h11);
      chk("R4 reserved size", int'(err_rsvd), 1);
      chk("R4 word kept", int'(mode_reg), 'h1A);
      cfg_write(21'h3A);
      chk("R4 upper bit word kept", int'(mode_reg), 'h1A);

      // deep power-down
      cfg_write(21'h00);
      chk("R7 active after clear", int'(pstate), 0);
      zz_n = 0; idle(10);
      chk("R5 deep entered", int'(pstate), 3);
      zz_n = 1; idle(5);
      chk("R6 deep held", int'(pstate), 3);
      idle(40);
      chk("R8 recovering", int'(pstate), 4);
      chk("R8 word default", int'(mode_reg), 'h10);
      zz_n = 0; idle(50); zz_n = 1; idle(2);
      chk("R8 fall ignored", int'(pstate), 4);
      rd_acc(21'h000100);
      chk("R11 access in recovery", int'(err_recov), 1);
      idle(REC);
      chk("R8 recovery done", int'(pstate), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule